// File: doc/BRIEF.md
# Multi-Error ECC Correction Applier

This block finishes the correction of one 512-byte data chunk after a four-error-capable decoder has processed it. It is started with the four syndrome words of the chunk. When they are all zero it reports a clean chunk at once. Otherwise it starts the decoder's locator search and waits for the search to finish. It then reads the decoder's state, error count, and packed locator and value words. For every reported error it turns the raw locator into a byte offset and applies the correction to the chunk buffer with one read-modify-write per byte.

The buffer is reached through a single request channel with a valid/ready handshake and a separate read-response strobe. A request is accepted on a rising edge where both `mem_req_valid` and `mem_req_ready` are high. While valid is high and ready is low, the block holds the request unchanged. Each accepted read is answered by exactly one `mem_rsp_valid` pulse in a later cycle. The block accepts a response in every cycle, so the response side has no ready signal. The decoder status and the start/done pins are plain level signals.

Top module: `ecc_fix_applier`

## Requirements
- R1: When `start` is accepted with an all-zero `syndrome`, the block raises `done` without pulsing `dec_start` and without any buffer request, and reports `fix_count` = 0 and `uncorrectable` = 0.
- R2: With a nonzero syndrome, the block pulses `dec_start` for exactly one cycle. It then ignores `dec_state` until it has seen `dec_state` >= 4, or until ARM_TIMEOUT cycles have passed (default 64), whichever comes first.
- R3: After that arming window, the block keeps waiting for as long as `dec_state` is 4 or more. The first value below 4 is taken as the final state.
- R4: Final state 0 ends the job with count 0 and `uncorrectable` = 0. Final state 1 ends it with `uncorrectable` = 1 and count 0. Neither makes a buffer access.
- R5: Final states 2 and 3 mean 1 + `dec_count` errors, handled in order 0, 1, 2, 3. Errors 0 and 1 come from `dec_addr_lo`/`dec_val_lo`, and errors 2 and 3 from `dec_addr_hi`/`dec_val_hi`. Even errors use bits [15:0] of the word and odd errors use bits [31:16]. The raw locator is bits [9:0] of that half, and the error byte is bits [7:0] of the value half.
- R6: The byte offset is 519 minus the raw locator. Only offsets 0..511 (raw 8..519) are corrected and counted. Any other entry makes no buffer access and is not counted. An error byte of zero still counts.
- R7: Each correction is a read of the offset, followed after its response by a write to the same offset of (read data XOR error byte). Corrections run one at a time, so repeated offsets accumulate.
- R8: While `mem_req_valid` is high and `mem_req_ready` is low, the request's valid, write flag, address and data stay stable.
- R9: `done` is a one-cycle pulse. `fix_count` and `uncorrectable` are valid with it and hold until the next accepted start. A `start` while a job is running is ignored.
- R10: After reset the block is idle, with `done`, `dec_start` and `mem_req_valid` low and the results cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a job (taken only when idle) |
| syndrome | input | 128 | Four 32-bit syndrome words of the chunk |
| dec_start | output | 1 | One-cycle pulse launching the locator search |
| dec_state | input | 4 | Decoder state: 0 clean, 1 too many errors, 2/3 ready, >=4 busy |
| dec_count | input | 2 | Error count minus one |
| dec_addr_lo | input | 32 | Locators of errors 0 (bits 15:0) and 1 (bits 31:16) |
| dec_addr_hi | input | 32 | Locators of errors 2 and 3 |
| dec_val_lo | input | 32 | Error values of errors 0 and 1 |
| dec_val_hi | input | 32 | Error values of errors 2 and 3 |
| mem_req_valid | output | 1 | Buffer request valid |
| mem_req_ready | input | 1 | Buffer request accepted |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_addr | output | 9 | Byte offset in the chunk |
| mem_req_wdata | output | 8 | Write data |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 8 | Read data |
| done | output | 1 | Job finished (one cycle) |
| fix_count | output | 3 | Bytes corrected |
| uncorrectable | output | 1 | Decoder reported five or more errors |

## Verification
Before the search is armed, the decoder model presents a stale "ready" state carrying locators that point into the buffer. A block that accepts the final state too early writes to a byte that no expected write covers. One run never shows a busy state, so the block has to fall back to the timeout; a block without that fallback hangs, and one that skips the wait finishes too soon. The locator mix includes raw values just outside 8..519, junk above bit 9, a zero error byte, unused entries beyond the count, and two errors on the same byte. These expose a wrong bias, a missing mask, a wrong half or word choice, and a skipped read-back that would lose the first fix. Random back-pressure and a response latency that varies from request to request check that requests stay stable while stalled.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;
  localparam int N_ENTRY = 4;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_KICK, SQ_ARM, SQ_PICK, SQ_FIX, SQ_DONE
  } seq_t;

  typedef enum logic [1:0] {PL_OFF, PL_ARM, PL_WAIT} poll_t;

  typedef enum logic [1:0] {RM_IDLE, RM_RD, RM_RWAIT, RM_WR} rmw_t;

  localparam logic [3:0] DEC_CLEAN = 4'd0;
  localparam logic [3:0] DEC_FAIL  = 4'd1;

  function automatic logic dec_is_busy(input logic [3:0] s);
    return s >= 4'd4;
  endfunction
endpackage

// File: rtl/efa_poll_ctrl.sv
module efa_poll_ctrl
  import ecc_fix_pkg::*;
#(
  parameter int ARM_TIMEOUT = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic [3:0] dec_state,
  output logic       final_valid,
  output logic [3:0] final_code
);
  localparam int CW = $clog2(ARM_TIMEOUT + 1);
  localparam logic [CW-1:0] LAST = CW'(ARM_TIMEOUT - 1);

  poll_t          phase;
  logic [CW-1:0]  wait_cnt;

  assign final_valid = (phase == PL_WAIT) && !dec_is_busy(dec_state);
  assign final_code  = dec_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PL_OFF;
      wait_cnt <= '0;
    end else begin
      case (phase)
        PL_OFF: if (arm) begin
          phase    <= PL_ARM;
          wait_cnt <= '0;
        end
        PL_ARM: begin
          if (dec_is_busy(dec_state) || wait_cnt == LAST) phase <= PL_WAIT;
          else wait_cnt <= wait_cnt + 1'b1;
        end
        PL_WAIT: if (final_valid) phase <= PL_OFF;
        default: phase <= PL_OFF;
      endcase
    end
  end

  // R2: a final state is never reported before the arming window closed
  a_r2_window_respected: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PL_ARM && !dec_is_busy(dec_state) && wait_cnt != LAST) |=> !final_valid);
endmodule

// File: rtl/efa_locator_unpack.sv
module efa_locator_unpack
  import ecc_fix_pkg::*;
#(
  parameter int CHUNK_BYTES = 512,
  parameter int LOC_W       = 10,
  parameter int BIAS        = CHUNK_BYTES + 7,
  parameter int ADDR_W      = $clog2(CHUNK_BYTES)
) (
  input  logic [31:0]       addr_lo,
  input  logic [31:0]       addr_hi,
  input  logic [31:0]       val_lo,
  input  logic [31:0]       val_hi,
  input  logic [1:0]        idx,
  output logic              hit,
  output logic [ADDR_W-1:0] offset,
  output logic [7:0]        flip
);
  localparam int XW = LOC_W + 1;
  localparam logic [XW-1:0] BIAS_X  = XW'(BIAS);
  localparam logic [XW-1:0] LIMIT_X = XW'(CHUNK_BYTES);

  logic              hit_v  [N_ENTRY];
  logic [ADDR_W-1:0] off_v  [N_ENTRY];
  logic [7:0]        flip_v [N_ENTRY];

  for (genvar g = 0; g < N_ENTRY; g++) begin : g_entry
    localparam int HS = (g % 2) * 16;
    logic [31:0]   aw, vw;
    logic [XW-1:0] raw_x, diff;
    assign aw        = (g < 2) ? addr_lo : addr_hi;
    assign vw        = (g < 2) ? val_lo  : val_hi;
    assign raw_x     = {1'b0, aw[HS +: LOC_W]};
    assign diff      = BIAS_X - raw_x;
    assign hit_v[g]  = (raw_x <= BIAS_X) && (diff < LIMIT_X);
    assign off_v[g]  = diff[ADDR_W-1:0];
    assign flip_v[g] = vw[HS +: 8];
  end

  assign hit    = hit_v[idx];
  assign offset = off_v[idx];
  assign flip   = flip_v[idx];
endmodule

// File: rtl/efa_rmw_engine.sv
module efa_rmw_engine
  import ecc_fix_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [7:0]        go_flip,
  output logic              finished,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [7:0]        mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [7:0]        mem_rsp_data
);
  rmw_t              st;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        flip_q, wdata_q;

  assign mem_req_valid = (st == RM_RD) || (st == RM_WR);
  assign mem_req_write = (st == RM_WR);
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = wdata_q;
  assign finished      = (st == RM_WR) && mem_req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= RM_IDLE;
      addr_q  <= '0;
      flip_q  <= '0;
      wdata_q <= '0;
    end else begin
      case (st)
        RM_IDLE: if (go) begin
          st     <= RM_RD;
          addr_q <= go_addr;
          flip_q <= go_flip;
        end
        RM_RD:    if (mem_req_ready) st <= RM_RWAIT;
        RM_RWAIT: if (mem_rsp_valid) begin
          wdata_q <= mem_rsp_data ^ flip_q;
          st      <= RM_WR;
        end
        RM_WR:    if (mem_req_ready) st <= RM_IDLE;
        default:  st <= RM_IDLE;
      endcase
    end
  end

  // R8: a stalled request is held unchanged
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_write)
      && $stable(mem_req_addr) && $stable(mem_req_wdata)));
endmodule

// File: rtl/ecc_fix_applier.sv
module ecc_fix_applier
  import ecc_fix_pkg::*;
#(
  parameter int CHUNK_BYTES = 512,
  parameter int LOC_W       = 10,
  parameter int SYN_WORDS   = 4,
  parameter int ARM_TIMEOUT = 64,
  localparam int ADDR_W     = $clog2(CHUNK_BYTES),
  localparam int SYN_W      = 32 * SYN_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SYN_W-1:0]  syndrome,
  output logic              dec_start,
  input  logic [3:0]        dec_state,
  input  logic [1:0]        dec_count,
  input  logic [31:0]       dec_addr_lo,
  input  logic [31:0]       dec_addr_hi,
  input  logic [31:0]       dec_val_lo,
  input  logic [31:0]       dec_val_hi,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [7:0]        mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [7:0]        mem_rsp_data,
  output logic              done,
  output logic [2:0]        fix_count,
  output logic              uncorrectable
);
  seq_t              seq;
  logic [1:0]        idx_q, last_q;
  logic [31:0]       alo_q, ahi_q, vlo_q, vhi_q;
  logic [2:0]        cnt_q;
  logic              unc_q;
  logic              final_valid;
  logic [3:0]        final_code;
  logic              e_hit;
  logic [ADDR_W-1:0] e_off;
  logic [7:0]        e_flip;
  logic              rmw_go, rmw_finished;

  assign dec_start     = (seq == SQ_KICK);
  assign done          = (seq == SQ_DONE);
  assign fix_count     = cnt_q;
  assign uncorrectable = unc_q;
  assign rmw_go        = (seq == SQ_PICK) && e_hit;

  efa_poll_ctrl #(.ARM_TIMEOUT(ARM_TIMEOUT)) u_poll (
    .clk(clk), .rst_n(rst_n), .arm(dec_start), .dec_state(dec_state),
    .final_valid(final_valid), .final_code(final_code)
  );

  efa_locator_unpack #(.CHUNK_BYTES(CHUNK_BYTES), .LOC_W(LOC_W)) u_unpack (
    .addr_lo(alo_q), .addr_hi(ahi_q), .val_lo(vlo_q), .val_hi(vhi_q),
    .idx(idx_q), .hit(e_hit), .offset(e_off), .flip(e_flip)
  );

  efa_rmw_engine #(.ADDR_W(ADDR_W)) u_rmw (
    .clk(clk), .rst_n(rst_n), .go(rmw_go), .go_addr(e_off), .go_flip(e_flip),
    .finished(rmw_finished),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq    <= SQ_IDLE;
      idx_q  <= '0;
      last_q <= '0;
      alo_q  <= '0;
      ahi_q  <= '0;
      vlo_q  <= '0;
      vhi_q  <= '0;
      cnt_q  <= '0;
      unc_q  <= 1'b0;
    end else begin
      case (seq)
        SQ_IDLE: if (start) begin
          cnt_q <= '0;
          unc_q <= 1'b0;
          seq   <= (|syndrome) ? SQ_KICK : SQ_DONE;
        end
        SQ_KICK: seq <= SQ_ARM;
        SQ_ARM: if (final_valid) begin
          if (final_code == DEC_CLEAN) begin
            seq <= SQ_DONE;
          end else if (final_code == DEC_FAIL) begin
            unc_q <= 1'b1;
            seq   <= SQ_DONE;
          end else begin
            alo_q  <= dec_addr_lo;
            ahi_q  <= dec_addr_hi;
            vlo_q  <= dec_val_lo;
            vhi_q  <= dec_val_hi;
            last_q <= dec_count;
            idx_q  <= '0;
            seq    <= SQ_PICK;
          end
        end
        SQ_PICK: begin
          if (e_hit) seq <= SQ_FIX;
          else if (idx_q == last_q) seq <= SQ_DONE;
          else idx_q <= idx_q + 1'b1;
        end
        SQ_FIX: if (rmw_finished) begin
          cnt_q <= cnt_q + 1'b1;
          if (idx_q == last_q) seq <= SQ_DONE;
          else begin
            idx_q <= idx_q + 1'b1;
            seq   <= SQ_PICK;
          end
        end
        SQ_DONE: seq <= SQ_IDLE;
        default: seq <= SQ_IDLE;
      endcase
    end
  end

  // R2: the decoder launch is a single-cycle pulse
  a_r2_kick_single: assert property (@(posedge clk) disable iff (!rst_n)
    dec_start |=> !dec_start);
  // R9: completion is a single-cycle pulse
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R4: an uncorrectable result never reports corrected bytes
  a_r4_fail_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    (done && uncorrectable) |-> (fix_count == 3'd0));
  // R10: no buffer traffic while idle
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (seq == SQ_IDLE) |-> !mem_req_valid);
endmodule

// File: tb/ecc_fix_applier_tb.sv
module ecc_fix_applier_tb;
  localparam int TMO = 64;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n, start, dec_start, mem_req_valid, mem_req_ready, mem_req_write;
  logic [127:0] syndrome;
  logic [3:0]   dec_state;
  logic [1:0]   dec_count;
  logic [31:0]  dec_addr_lo, dec_addr_hi, dec_val_lo, dec_val_hi;
  logic [8:0]   mem_req_addr;
  logic [7:0]   mem_req_wdata, mem_rsp_data;
  logic         mem_rsp_valid, done, uncorrectable;
  logic [2:0]   fix_count;

  ecc_fix_applier #(.ARM_TIMEOUT(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .syndrome(syndrome),
    .dec_start(dec_start), .dec_state(dec_state), .dec_count(dec_count),
    .dec_addr_lo(dec_addr_lo), .dec_addr_hi(dec_addr_hi),
    .dec_val_lo(dec_val_lo), .dec_val_hi(dec_val_hi),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .fix_count(fix_count),
    .uncorrectable(uncorrectable)
  );

  int n_checks = 0, n_fail = 0, cyc = 0;
  logic [7:0] mem [512];
  logic [7:0] gold [512];
  int q_rd[$], q_wa[$], q_wd[$];

  // decoder script
  bit sc_on = 0;
  int sc_t = 0, sc_stale = 0, sc_busy = 0;
  logic [3:0]  sc_state;
  logic [1:0]  sc_cnt;
  logic [31:0] sc_alo, sc_ahi, sc_vlo, sc_vhi;

  // buffer model
  logic [15:0] lfsr = 16'hACE1;
  bit pend = 0; int pend_dly = 0; logic [8:0] pend_addr;
  bit p_valid = 0, p_ready = 0, p_write = 0;
  logic [8:0] p_addr; logic [7:0] p_wdata;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(0, "R9", "watchdog expired", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
    if (rst_n) begin
      if (p_valid && p_ready) begin
        if (!p_write) begin
          check(q_rd.size() > 0 && q_rd[0] == int'(p_addr), "R7", "read address",
                p_addr, q_rd.size() > 0 ? q_rd[0] : -1);
          if (q_rd.size() > 0) void'(q_rd.pop_front());
          pend = 1; pend_addr = p_addr; pend_dly = int'(lfsr[2:1]) % 3;
        end else begin
          check(q_wa.size() > 0 && q_wa[0] == int'(p_addr), "R6", "write address",
                p_addr, q_wa.size() > 0 ? q_wa[0] : -1);
          check(q_wd.size() > 0 && q_wd[0] == int'(p_wdata), "R7", "write data",
                p_wdata, q_wd.size() > 0 ? q_wd[0] : -1);
          if (q_wa.size() > 0) begin void'(q_wa.pop_front()); void'(q_wd.pop_front()); end
          mem[p_addr] = p_wdata;
        end
      end else if (p_valid) begin
        check(mem_req_valid && mem_req_write == p_write && mem_req_addr == p_addr &&
              mem_req_wdata == p_wdata, "R8", "stalled request changed",
              mem_req_addr, p_addr);
      end
      mem_rsp_valid = 0;
      if (pend) begin
        if (pend_dly == 0) begin
          mem_rsp_valid = 1; mem_rsp_data = mem[pend_addr]; pend = 0;
        end else pend_dly--;
      end
      if (dec_start) begin sc_on = 1; sc_t = 0; end
      else if (sc_on) sc_t++;
      if (sc_on && sc_t >= sc_stale + sc_busy) begin
        dec_state = sc_state; dec_count = sc_cnt;
        dec_addr_lo = sc_alo; dec_addr_hi = sc_ahi; dec_val_lo = sc_vlo; dec_val_hi = sc_vhi;
      end else if (sc_on && sc_t >= sc_stale) begin
        dec_state = 4'(4 + (sc_t % 12)); dec_count = 2'd3;
        dec_addr_lo = 32'h00C8_00C8; dec_addr_hi = 32'h00C8_00C8;
        dec_val_lo = 32'h00FF_00FF; dec_val_hi = 32'h00FF_00FF;
      end else begin
        dec_state = 4'd3; dec_count = 2'd3;
        dec_addr_lo = 32'h00C8_00C8; dec_addr_hi = 32'h00C8_00C8;
        dec_val_lo = 32'h00FF_00FF; dec_val_hi = 32'h00FF_00FF;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_req_ready = lfsr[0] | lfsr[3];
      p_valid = mem_req_valid; p_ready = mem_req_ready; p_write = mem_req_write;
      p_addr = mem_req_addr; p_wdata = mem_req_wdata;
    end
  end

  task automatic run_case(input string name, input logic [127:0] syn, input int stale,
                          input int busy, input logic [3:0] fst, input logic [1:0] fcnt,
                          input logic [31:0] alo, input logic [31:0] ahi,
                          input logic [31:0] vlo, input logic [31:0] vhi);
    int exp_cnt = 0, kicks = 0, kick_at = -1, waited = 0, bad = 0;
    bit exp_unc = 0, got = 0;
    logic [2:0] held;
    sc_stale = stale; sc_busy = busy; sc_state = fst; sc_cnt = fcnt;
    sc_alo = alo; sc_ahi = ahi; sc_vlo = vlo; sc_vhi = vhi;
    if (syn != 0) begin
      if (fst == 4'd1) exp_unc = 1;
      else if (fst >= 4'd2) begin
        for (int i = 0; i <= int'(fcnt); i++) begin
          logic [31:0] w, v; int raw, off; logic [7:0] f;
          w = (i < 2) ? alo : ahi; v = (i < 2) ? vlo : vhi;
          raw = (i % 2) ? int'(w[25:16]) : int'(w[9:0]);
          f   = (i % 2) ? v[23:16] : v[7:0];
          off = 519 - raw;
          if (off >= 0 && off < 512) begin
            q_rd.push_back(off); q_wa.push_back(off);
            gold[off] = gold[off] ^ f; q_wd.push_back(int'(gold[off]));
            exp_cnt++;
          end
        end
      end
    end
    start = 1; syndrome = syn;
    @(negedge clk); start = 0;
    if (dec_start) begin kicks++; kick_at = waited; end
    while (!got && waited < 4000) begin
      @(negedge clk); waited++;
      if (dec_start) begin kicks++; kick_at = waited; end
      if (waited == 3) start = 1;
      if (waited == 4) start = 0;
      if (done) got = 1;
    end
    check(got, "R9", {name, ": done seen"}, got, 1);
    check(kicks == ((syn != 0) ? 1 : 0), (syn != 0) ? "R2" : "R1",
          {name, ": decoder launches"}, kicks, (syn != 0) ? 1 : 0);
    check(fix_count == 3'(exp_cnt), "R6", {name, ": corrected count"}, fix_count, exp_cnt);
    check(uncorrectable == exp_unc, "R4", {name, ": uncorrectable flag"}, uncorrectable, exp_unc);
    if (syn != 0 && stale == 0 && busy == 0)
      check(waited - kick_at >= TMO, "R2", {name, ": timeout wait"}, waited - kick_at, TMO);
    held = fix_count;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(!done && fix_count == held, "R9", {name, ": result held, no second done"},
            fix_count, held);
    end
    sc_on = 0;
    check(q_rd.size() == 0 && q_wa.size() == 0, "R7", {name, ": all expected accesses made"},
          q_rd.size() + q_wa.size(), 0);
    for (int a = 0; a < 512; a++) if (mem[a] !== gold[a]) bad++;
    check(bad == 0, "R5", {name, ": buffer contents"}, bad, 0);
    q_rd.delete(); q_wa.delete(); q_wd.delete();
  endtask

  initial begin
    rst_n = 0; start = 0; syndrome = '0; mem_req_ready = 0; mem_rsp_valid = 0;
    mem_rsp_data = '0; dec_state = 4'd3; dec_count = 2'd3;
    dec_addr_lo = 32'h00C8_00C8; dec_addr_hi = 32'h00C8_00C8;
    dec_val_lo = 32'h00FF_00FF; dec_val_hi = 32'h00FF_00FF;
    for (int a = 0; a < 512; a++) begin mem[a] = 8'(a * 37 + 5); gold[a] = mem[a]; end
    repeat (4) @(negedge clk);
    check(!done && !dec_start && !mem_req_valid && fix_count == 0 && !uncorrectable,
          "R10", "reset state", {done, dec_start, mem_req_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    run_case("R1 zero syndrome", '0, 2, 4, 4'd2, 2'd0, 32'h0000_0100, 0, 32'h0000_0011, 0);
    run_case("R4 clean", 128'h1, 2, 4, 4'd0, 2'd0, 0, 0, 0, 0);
    run_case("R4 too many", {32'h8, 96'h0}, 3, 5, 4'd1, 2'd2, 32'h0100_0100, 0, 32'h1111_1111, 0);
    run_case("R5 single at 519", 128'h5, 1, 3, 4'd2, 2'd0, 32'h0000_0207, 0, 32'h0000_005A, 0);
    run_case("R6 edges", 128'h7, 2, 4, 4'd3, 2'd3, 32'h0007_FC08, 32'h0064_0208,
             32'h0011_03A5, 32'h0077_0033);
    run_case("R7 repeated offset", 128'h9, 2, 3, 4'd2, 2'd1, 32'h0100_0100, 32'h0050_0060,
             32'h000F_00F0, 32'h0022_0044);
    run_case("R2 timeout", 128'hB, 0, 0, 4'd2, 2'd2, 32'h0010_0020, 32'h03FF_0030,
             32'h0001_0002, 32'h0000_0004);
    run_case("R3 stale then busy", 128'hD, 5, 6, 4'd3, 2'd3, 32'h0200_0008, 32'h01FF_0150,
             32'h0081_0042, 32'h0024_0000);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule